// File: doc/BRIEF.md
# Mask-Predicated Vector Writeback

This block is the last stage of a 16-lane vector datapath. Each cycle it can take one vector result, made of one 32-bit word per lane, together with a per-lane predicate mask. A destination selector picks one of two targets for the result: an entry of a small vector register file, or a memory word address. Only lanes whose mask bit is set are committed. Every other lane of the destination keeps the value it held before. Lane contents are treated as raw 32-bit words, so integer and floating-point elements pass through the same path.

For a register destination, the block merges the new lanes into the stored vector and writes the merged vector back in one cycle. A read port returns any register. When the register being read is also being written in that cycle, the read port returns the merged value through a bypass. For a memory destination, the block registers a store request that carries four byte enables per active lane. The store is suppressed entirely when the mask is empty. In every case a completion pulse follows each accepted result.

Top module: `vec_wb`

## Requirements
- R1: A register-destination result (`wb_dest_i`=0) with `wb_valid_i` high replaces, from the next cycle on, exactly those lanes of register `wb_reg_i` whose mask bit is 1. All other lanes of that register, and all other registers, keep their values.
- R2: Mask bit i governs lane i, and lane i occupies bits [32*i+31 : 32*i] of every vector port. Lane 0 is the least significant word.
- R3: A memory-destination result (`wb_dest_i`=1) with a non-zero mask drives `mem_we_o`=1 in the following cycle, with `mem_addr_o` equal to `wb_addr_i` and `mem_wdata_o` equal to `wb_data_i`.
- R4: In that store cycle, byte enables 4*i to 4*i+3 of `mem_be_o` equal mask bit i. Masked-off lanes therefore enable no byte.
- R5: An all-zero mask changes no register and raises no `mem_we_o`, for either destination.
- R6: While a register write is presented, reading the same register through `rd_reg_i` returns the merged value (new lanes where the mask is 1, old lanes elsewhere) in that same cycle.
- R7: After reset, every register reads as zero, and `mem_we_o` and `done_o` are low.
- R8: A memory-destination result leaves the register file unchanged. A register-destination result never raises `mem_we_o`.
- R9: `done_o` is high in the cycle after each cycle with `wb_valid_i` high, whatever the mask, and low otherwise.
- R10: While `wb_valid_i` is low, mask, data, selector and address inputs have no effect: registers are unchanged and `mem_we_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wb_valid_i | input | 1 | A result is presented this cycle |
| wb_dest_i | input | 1 | Destination: 0 vector register, 1 memory |
| wb_reg_i | input | 3 | Destination register index |
| wb_addr_i | input | 10 | Destination memory word address |
| wb_mask_i | input | 16 | Per-lane predicate, bit i for lane i |
| wb_data_i | input | 512 | Result lanes, lane 0 in bits 31:0 |
| rd_reg_i | input | 3 | Register read index |
| rd_data_o | output | 512 | Register read data, with bypass of a same-cycle write |
| mem_we_o | output | 1 | Memory store strobe |
| mem_addr_o | output | 10 | Memory store word address |
| mem_be_o | output | 64 | Memory byte enables, four per lane |
| mem_wdata_o | output | 512 | Memory store data |
| done_o | output | 1 | Completion pulse one cycle after a result |

## Verification
The assertions assume the control inputs are known (never X) while `wb_valid_i` is high. The idle-stability check also assumes that no other agent alters register contents. Every write in the stimulus goes through the writeback port, and all inputs are driven with defined values from reset onward, including during idle cycles, where the bench deliberately toggles mask, data and address. The bench keeps its own register image, and its lane patterns are chosen so that each lane holds a distinct value. With distinct lane values, a swapped lane or a wrong mask bit cannot match the expected image by accident.

// File: rtl/vec_wb_pkg.sv
package vec_wb_pkg;
  typedef enum logic {
    DEST_VREG = 1'b0,
    DEST_MEM  = 1'b1
  } wb_dest_e;
endpackage

// File: rtl/vec_wb_merge.sv
module vec_wb_merge #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0] old_i,
  input  logic [VEC_W-1:0] new_i,
  input  logic [LANES-1:0] mask_i,
  output logic [VEC_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*LANE_W +: LANE_W] =
      mask_i[l] ? new_i[l*LANE_W +: LANE_W] : old_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vec_wb_regfile.sv
module vec_wb_regfile #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wreg_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] ra_i,
  output logic [VEC_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0] rb_i,
  output logic [VEC_W-1:0] rb_data_o
);
  logic [VEC_W-1:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (we_i && wreg_i == IDX_W'(r)) regs_q[r] <= wdata_i;
    end
  end

  assign ra_data_o = regs_q[ra_i];
  assign rb_data_o = regs_q[rb_i];
endmodule

// File: rtl/vec_wb_store.sv
module vec_wb_store #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned BPL   = LANE_W / 8,
  localparam int unsigned BE_W  = LANES * BPL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VEC_W-1:0]  data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [VEC_W-1:0]  wdata_o
);
  logic [BE_W-1:0] be_d;
  logic            fire;

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_d[l*BPL +: BPL] = {BPL{mask_i[l]}};
  end

  // an empty mask issues no store at all
  assign fire = req_i && (|mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= fire;
      be_o <= fire ? be_d : '0;
      if (fire) begin
        addr_o  <= addr_i;
        wdata_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/vec_wb.sv
module vec_wb
  import vec_wb_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned BE_W  = VEC_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_valid_i,
  input  logic              wb_dest_i,
  input  logic [IDX_W-1:0]  wb_reg_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [LANES-1:0]  wb_mask_i,
  input  logic [VEC_W-1:0]  wb_data_i,
  input  logic [IDX_W-1:0]  rd_reg_i,
  output logic [VEC_W-1:0]  rd_data_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [VEC_W-1:0]  mem_wdata_o,
  output logic              done_o
);
  logic             to_reg, to_mem, reg_we;
  logic [VEC_W-1:0] old_vec, rd_raw, merged;

  assign to_reg = wb_valid_i && (wb_dest_e'(wb_dest_i) == DEST_VREG);
  assign to_mem = wb_valid_i && (wb_dest_e'(wb_dest_i) == DEST_MEM);
  assign reg_we = to_reg && (|wb_mask_i);

  vec_wb_regfile #(.LANES(LANES), .LANE_W(LANE_W), .NREGS(NREGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we),
    .wreg_i    (wb_reg_i),
    .wdata_i   (merged),
    .ra_i      (wb_reg_i),
    .ra_data_o (old_vec),
    .rb_i      (rd_reg_i),
    .rb_data_o (rd_raw)
  );

  vec_wb_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .old_i    (old_vec),
    .new_i    (wb_data_i),
    .mask_i   (wb_mask_i),
    .merged_o (merged)
  );

  // same-cycle read of the written register sees the merged vector
  assign rd_data_o = (reg_we && rd_reg_i == wb_reg_i) ? merged : rd_raw;

  vec_wb_store #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (to_mem),
    .mask_i  (wb_mask_i),
    .addr_i  (wb_addr_i),
    .data_i  (wb_data_i),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= wb_valid_i;
  end
endmodule

// File: rtl/vec_wb_chk.sv
module vec_wb_chk #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned BPL   = LANE_W / 8,
  localparam int unsigned BE_W  = VEC_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_valid_i,
  input logic              wb_dest_i,
  input logic [ADDR_W-1:0] wb_addr_i,
  input logic [LANES-1:0]  wb_mask_i,
  input logic [VEC_W-1:0]  wb_data_i,
  input logic [IDX_W-1:0]  rd_reg_i,
  input logic [VEC_W-1:0]  rd_data_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BE_W-1:0]   mem_be_o,
  input logic [VEC_W-1:0]  mem_wdata_o,
  input logic              done_o
);
  logic [BE_W-1:0] exp_be;
  always_comb begin
    exp_be = '0;
    for (int l = 0; l < LANES; l++) exp_be[l*BPL +: BPL] = {BPL{wb_mask_i[l]}};
  end

  a_r3_store_issued: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_dest_i && |wb_mask_i) |=>
      (mem_we_o && mem_addr_o == $past(wb_addr_i) && mem_wdata_o == $past(wb_data_i)));

  a_r4_be_per_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_dest_i) |=> (mem_be_o == $past(exp_be)));

  a_r5_empty_mask_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_mask_i == '0) |=> !mem_we_o);

  a_r8_reg_dest_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !wb_dest_i) |=> !mem_we_o);

  a_r9_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> done_o);

  a_r9_no_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |=> !done_o);

  a_r10_idle_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |=> !mem_we_o);

  a_r10_idle_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |=> (!(!wb_valid_i && $stable(rd_reg_i)) || $stable(rd_data_o)));
endmodule

bind vec_wb vec_wb_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wb_valid_i  (wb_valid_i),
  .wb_dest_i   (wb_dest_i),
  .wb_addr_i   (wb_addr_i),
  .wb_mask_i   (wb_mask_i),
  .wb_data_i   (wb_data_i),
  .rd_reg_i    (rd_reg_i),
  .rd_data_o   (rd_data_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o)
);

// File: tb/vec_wb_bench.sv
module vec_wb_bench;
  localparam int LANES = 16, LANE_W = 32, NREGS = 8, ADDR_W = 10;
  localparam int VEC_W = LANES * LANE_W, IDX_W = 3, BE_W = VEC_W / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wb_valid = 0, wb_dest = 0;
  logic [IDX_W-1:0] wb_reg = '0, rd_reg = '0;
  logic [ADDR_W-1:0] wb_addr = '0;
  logic [LANES-1:0] wb_mask = '0;
  logic [VEC_W-1:0] wb_data = '0;
  logic [VEC_W-1:0] rd_data, mem_wdata;
  logic mem_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [BE_W-1:0] mem_be;

  always #10 clk = ~clk;

  vec_wb u_vec_wb (
    .clk_i(clk), .rst_ni(rst_n), .wb_valid_i(wb_valid), .wb_dest_i(wb_dest),
    .wb_reg_i(wb_reg), .wb_addr_i(wb_addr), .wb_mask_i(wb_mask), .wb_data_i(wb_data),
    .rd_reg_i(rd_reg), .rd_data_o(rd_data), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .done_o(done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [VEC_W-1:0] model [NREGS];

  task automatic check(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] pat(input int seed);
    logic [VEC_W-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l*LANE_W +: LANE_W] = 32'(seed) * 32'h9E37_79B9 + 32'(l) * 32'h0101_0111 + 32'h5;
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] merge(input logic [VEC_W-1:0] o, input logic [VEC_W-1:0] n,
                                             input logic [LANES-1:0] m);
    logic [VEC_W-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l*LANE_W +: LANE_W] = m[l] ? n[l*LANE_W +: LANE_W] : o[l*LANE_W +: LANE_W];
    return v;
  endfunction

  function automatic logic [BE_W-1:0] bes(input logic [LANES-1:0] m);
    logic [BE_W-1:0] b;
    for (int l = 0; l < LANES; l++) b[l*4 +: 4] = {4{m[l]}};
    return b;
  endfunction

  task automatic check_regs(input string tag);
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      rd_reg = IDX_W'(r);
      #1;
      check(rd_data === model[r], tag, rd_data, model[r]);
    end
  endtask

  // one result; returns after outputs of the following cycle are checked
  task automatic op(input bit dest, input int rg, input int addr, input logic [LANES-1:0] m,
                    input logic [VEC_W-1:0] d);
    logic [VEC_W-1:0] exp_m;
    @(negedge clk);
    wb_valid = 1; wb_dest = dest; wb_reg = IDX_W'(rg); wb_addr = ADDR_W'(addr);
    wb_mask = m; wb_data = d; rd_reg = IDX_W'(rg);
    #1;
    exp_m = dest ? model[rg] : merge(model[rg], d, m);
    check(rd_data === exp_m, dest ? "R8 read during store" : "R6 bypass", rd_data, exp_m);
    @(posedge clk);
    #1;
    wb_valid = 0;
    check(done === 1'b1, "R9 done", VEC_W'(done), VEC_W'(1));
    if (dest && m != '0) begin
      check(mem_we === 1'b1, "R3 we", VEC_W'(mem_we), VEC_W'(1));
      check(mem_addr === ADDR_W'(addr), "R3 addr", VEC_W'(mem_addr), VEC_W'(ADDR_W'(addr)));
      check(mem_wdata === d, "R3 wdata", mem_wdata, d);
      check(mem_be === bes(m), "R4 be", VEC_W'(mem_be), VEC_W'(bes(m)));
    end else begin
      check(mem_we === 1'b0, dest ? "R5 empty store" : "R8 reg no store",
            VEC_W'(mem_we), VEC_W'(0));
    end
    if (!dest) model[rg] = exp_m;
  endtask

  initial begin
    for (int r = 0; r < NREGS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(mem_we === 1'b0 && done === 1'b0, "R7 outputs after reset",
          VEC_W'({mem_we, done}), VEC_W'(0));
    check_regs("R7 reset regs");

    // R1 R2: full write then walking single-lane masks across all registers
    for (int r = 0; r < NREGS; r++) op(0, r, 0, '1, pat(100 + r));
    check_regs("R1 full write");
    for (int l = 0; l < LANES; l++) begin
      op(0, l % NREGS, 0, LANES'(1) << l, pat(200 + l));
      @(negedge clk);
      rd_reg = IDX_W'(l % NREGS);
      #1;
      check(rd_data === model[l % NREGS], "R2 walking lane", rd_data, model[l % NREGS]);
    end
    check_regs("R1 after walking");

    // R1 R6: mixed masks, back-to-back
    op(0, 3, 0, 16'hA5A5, pat(300));
    op(0, 3, 0, 16'h0FF0, pat(301));
    op(0, 5, 0, 16'h8001, pat(302));
    check_regs("R1 mixed masks");

    // R5: empty mask to a register
    op(0, 2, 0, '0, pat(400));
    check_regs("R5 empty reg write");

    // R3 R4 R8: stores with several masks, including single lanes at both ends
    op(1, 1, 12, 16'hFFFF, pat(500));
    op(1, 4, 1023, 16'h0001, pat(501));
    op(1, 6, 7, 16'h8000, pat(502));
    op(1, 0, 300, 16'h3C5A, pat(503));
    for (int l = 0; l < LANES; l += 3) op(1, l % NREGS, l * 17, LANES'(1) << l, pat(510 + l));
    op(1, 0, 99, '0, pat(520));
    check_regs("R8 regs after stores");

    // R10: idle cycles with toggling inputs
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wb_valid = 0; wb_dest = k[0]; wb_reg = IDX_W'(k); wb_mask = '1;
      wb_addr = ADDR_W'(k * 5); wb_data = pat(600 + k);
      @(posedge clk);
      #1;
      check(mem_we === 1'b0 && done === 1'b0, "R10 idle outputs",
            VEC_W'({mem_we, done}), VEC_W'(0));
    end
    check_regs("R10 regs after idle");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule